// File: doc/BRIEF.md
# Watchdog Frequency Self-Recovery Controller

This block guards a clock frequency change requested by software. A new frequency code can arrive through a change strobe. Software can also update the PLL dividers directly. If a nonzero timeout in seconds is programmed, the block starts a supervision timer. Software proves the system survived the change by writing zero to the timeout field before the timer runs out. If it does not, the block falls back to a safe frequency code. It also raises a latched timeout flag and drives an active-low system reset pulse of fixed width.

The fallback code comes from a revert-mode bit. With the bit clear, the block restores the frequency code latched from the hardware straps. With the bit set, it restores the software code that was in force before the failing one. A two-deep history of software codes makes that possible. Time is measured in 1 ms ticks from a shared timebase, and a second is a parameterised number of ticks. A direct divider update first waits out a fixed settling window. Only then does the seconds count begin.

Top module: `freq_recovery_wdog`

## Requirements
- R1: After reset, `fs_out` equals `hw_fs`, `to_flag` is 0 and `rst_n_out` is 1.
- R2: A cycle with `sw_fs_wr` high loads `sw_fs` into `fs_out` at that clock edge. The previous `fs_out` value becomes the stored prior software code.
- R3: A frequency strobe while `to_code` is 0 arms nothing, so no reset pulse ever follows it.
- R4: After a `sw_fs_wr` with `to_code` = T (1 to 15), `rst_n_out` goes low at the edge of the T*TICKS_PER_SEC-th `ms_tick` after the strobe, and not before.
- R5: `rst_n_out` stays low for exactly PULSE_MS further ticks, and rises at the edge of the PULSE_MS-th tick after the expiry tick.
- R6: `to_flag` becomes 1 at the expiry edge and holds. It returns to 0 one cycle after `to_code` reads 0.
- R7: At expiry with `revert_sel` = 0, `fs_out` becomes `hw_fs`.
- R8: At expiry with `revert_sel` = 1, `fs_out` becomes the software code that preceded the one being supervised.
- R9: Setting `to_code` to 0 before expiry cancels the timer. No pulse follows, and `fs_out` keeps the new code.
- R10: A `div_wr` strobe leaves `fs_out` unchanged. It arms the timer so that expiry falls SETTLE_MS + T*TICKS_PER_SEC ticks after the strobe.
- R11: A new nonzero `to_code` value while the seconds count runs restarts the count from zero, using the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| to_code | input | TO_W | Timeout in seconds, 0 disables and clears |
| revert_sel | input | 1 | 0: fall back to strap code, 1: fall back to prior software code |
| sw_fs | input | FS_W | Software frequency code |
| sw_fs_wr | input | 1 | Strobe accepting `sw_fs` |
| div_wr | input | 1 | Strobe marking a direct divider update |
| hw_fs | input | FS_W | Frequency code latched from straps |
| fs_out | output | FS_W | Effective frequency select code |
| to_flag | output | 1 | Latched timeout status |
| rst_n_out | output | 1 | Active-low system reset pulse |

## Verification
The assertions assume that `ms_tick` is a single-cycle pulse. They also assume that `hw_fs` is constant after reset, and that an expiry is never followed by another expiry while the reset pulse is still low. The bench keeps to these assumptions. It spaces ticks with an idle cycle between them and holds the strap code fixed. It also waits out every pulse and writes zero to the timeout field before the next scenario rearms. A small tick-per-second value keeps each expiry within a few hundred cycles.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_SETTLE = 2'd1,
    WD_RUN    = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdr_history.sv
// Two-deep software frequency history; the head is the effective code.
module wdr_history #(
  parameter int FS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FS_W-1:0] hw_fs,
  input  logic [FS_W-1:0] sw_fs,
  input  logic            fs_go,
  input  logic            expire,
  input  logic            revert_sel,
  output logic [FS_W-1:0] fs_cur
);
  logic [FS_W-1:0] cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= hw_fs;
      prev_q <= hw_fs;
    end else if (expire) begin
      cur_q  <= revert_sel ? prev_q : hw_fs;
    end else if (fs_go) begin
      prev_q <= cur_q;
      cur_q  <= sw_fs;
    end
  end

  assign fs_cur = cur_q;
endmodule

// File: rtl/wdr_timer.sv
// Settling window and seconds counter; flags expiry for one cycle.
module wdr_timer
  import wdr_pkg::*;
#(
  parameter int TO_W      = 4,
  parameter int TPS       = 1000,
  parameter int SETTLE_MS = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [TO_W-1:0] to_code,
  input  logic            fs_go,
  input  logic            div_go,
  output logic            expire,
  output logic            armed
);
  localparam int MS_W = (TPS > 1) ? $clog2(TPS) : 1;

  wd_state_e       st_q;
  logic [MS_W-1:0] ms_q;
  logic [TO_W-1:0] sec_q, to_q;
  logic            settle_done;
  logic            to_zero, to_new, last_ms, last_sec;

  generate
    if (SETTLE_MS > 0) begin : g_settle
      localparam int SW = (SETTLE_MS > 1) ? $clog2(SETTLE_MS) : 1;
      logic [SW-1:0] set_q;
      always_ff @(posedge clk) begin
        if (rst || st_q != WD_SETTLE || div_go) set_q <= '0;
        else if (tick)                          set_q <= set_q + SW'(1);
      end
      assign settle_done = tick && (set_q == SW'(SETTLE_MS - 1));
    end else begin : g_nosettle
      assign settle_done = 1'b1;
    end
  endgenerate

  assign to_zero  = (to_code == '0);
  assign to_new   = (to_code != to_q) && !to_zero;
  assign last_ms  = (ms_q == MS_W'(TPS - 1));
  assign last_sec = (sec_q == to_code - TO_W'(1));
  assign expire   = (st_q == WD_RUN) && tick && last_ms && last_sec &&
                    !to_zero && !fs_go && !div_go && !to_new;
  assign armed    = (st_q != WD_IDLE);

  always_ff @(posedge clk) begin
    if (rst) to_q <= '0;
    else     to_q <= to_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= WD_IDLE;
      ms_q  <= '0;
      sec_q <= '0;
    end else if (to_zero) begin
      st_q <= WD_IDLE;
    end else if (fs_go) begin
      st_q  <= WD_RUN;
      ms_q  <= '0;
      sec_q <= '0;
    end else if (div_go) begin
      st_q <= WD_SETTLE;
    end else begin
      case (st_q)
        WD_SETTLE: if (settle_done) begin
          st_q  <= WD_RUN;
          ms_q  <= '0;
          sec_q <= '0;
        end
        WD_RUN: begin
          if (to_new) begin
            ms_q  <= '0;
            sec_q <= '0;
          end else if (tick) begin
            if (last_ms) begin
              ms_q <= '0;
              if (last_sec) st_q <= WD_IDLE;
              else          sec_q <= sec_q + TO_W'(1);
            end else begin
              ms_q <= ms_q + MS_W'(1);
            end
          end
        end
        default: st_q <= WD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdr_pulse.sv
// Fixed-width active-low reset pulse measured in ticks.
module wdr_pulse #(
  parameter int PULSE_MS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic expire,
  output logic rst_n
);
  localparam int CW = (PULSE_MS > 1) ? $clog2(PULSE_MS) : 1;
  logic [CW-1:0] cnt_q;
  logic          rst_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_q <= 1'b1;
      cnt_q   <= '0;
    end else if (expire) begin
      rst_n_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!rst_n_q && tick) begin
      if (cnt_q == CW'(PULSE_MS - 1)) rst_n_q <= 1'b1;
      else                            cnt_q   <= cnt_q + CW'(1);
    end
  end

  assign rst_n = rst_n_q;
endmodule

// File: rtl/freq_recovery_wdog.sv
module freq_recovery_wdog #(
  parameter int FS_W           = 4,
  parameter int TO_W           = 4,
  parameter int TICKS_PER_SEC  = 1000,
  parameter int PULSE_MS       = 6,
  parameter int SETTLE_MS      = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ms_tick,
  input  logic [TO_W-1:0] to_code,
  input  logic            revert_sel,
  input  logic [FS_W-1:0] sw_fs,
  input  logic            sw_fs_wr,
  input  logic            div_wr,
  input  logic [FS_W-1:0] hw_fs,
  output logic [FS_W-1:0] fs_out,
  output logic            to_flag,
  output logic            rst_n_out
);
  logic expire, armed, flag_q;

  wdr_timer #(.TO_W(TO_W), .TPS(TICKS_PER_SEC), .SETTLE_MS(SETTLE_MS)) timer_i (
    .clk(clk), .rst(rst), .tick(ms_tick), .to_code(to_code),
    .fs_go(sw_fs_wr), .div_go(div_wr), .expire(expire), .armed(armed)
  );

  wdr_history #(.FS_W(FS_W)) hist_i (
    .clk(clk), .rst(rst), .hw_fs(hw_fs), .sw_fs(sw_fs), .fs_go(sw_fs_wr),
    .expire(expire), .revert_sel(revert_sel), .fs_cur(fs_out)
  );

  wdr_pulse #(.PULSE_MS(PULSE_MS)) pulse_i (
    .clk(clk), .rst(rst), .tick(ms_tick), .expire(expire), .rst_n(rst_n_out)
  );

  always_ff @(posedge clk) begin
    if (rst)                 flag_q <= 1'b0;
    else if (to_code == '0)  flag_q <= 1'b0;
    else if (expire)         flag_q <= 1'b1;
  end

  assign to_flag = flag_q;
endmodule

// File: rtl/freq_recovery_wdog_chk.sv
module freq_recovery_wdog_chk #(
  parameter int FS_W = 4,
  parameter int TO_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ms_tick,
  input logic [TO_W-1:0] to_code,
  input logic            sw_fs_wr,
  input logic [FS_W-1:0] fs_out,
  input logic            to_flag,
  input logic            rst_n_out,
  input logic            expire,
  input logic            armed
);
  // R2 R7 R8: the code moves only on an accepted strobe or an expiry
  assert_fs_source_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(fs_out) |-> ($past(sw_fs_wr) || $past(expire)));

  // R5: the pulse ends only on a tick
  assert_pulse_end_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_out) |-> $past(ms_tick));

  // R6: a zero timeout clears the flag on the next cycle
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (to_code == '0) |=> !to_flag);

  // R6 R4: the flag rises only with an expiry, together with the reset pulse
  assert_flag_with_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(to_flag) |-> ($past(expire) && !rst_n_out));

  // R3 R9: a zero timeout leaves the timer disarmed
  assert_zero_disarms_R9: assert property (@(posedge clk) disable iff (rst)
    (to_code == '0) |=> !armed);
endmodule

bind freq_recovery_wdog freq_recovery_wdog_chk #(.FS_W(FS_W), .TO_W(TO_W)) chk_i (
  .clk(clk), .rst(rst), .ms_tick(ms_tick), .to_code(to_code),
  .sw_fs_wr(sw_fs_wr), .fs_out(fs_out), .to_flag(to_flag),
  .rst_n_out(rst_n_out), .expire(expire), .armed(armed)
);

// File: tb/freq_recovery_wdog_tb_top.sv
module freq_recovery_wdog_tb_top;
  localparam int FS_W = 4, TO_W = 4, TPS = 10, PULSE = 4, SETTLE = 3;
  localparam logic [FS_W-1:0] HW = 4'd7;

  logic clk = 1'b0, rst = 1'b1, ms_tick = 1'b0, revert_sel = 1'b0;
  logic sw_fs_wr = 1'b0, div_wr = 1'b0;
  logic [TO_W-1:0] to_code = '0;
  logic [FS_W-1:0] sw_fs = '0, hw_fs = HW;
  logic [FS_W-1:0] fs_out;
  logic to_flag, rst_n_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  freq_recovery_wdog #(.FS_W(FS_W), .TO_W(TO_W), .TICKS_PER_SEC(TPS),
                       .PULSE_MS(PULSE), .SETTLE_MS(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .to_code(to_code),
    .revert_sel(revert_sel), .sw_fs(sw_fs), .sw_fs_wr(sw_fs_wr),
    .div_wr(div_wr), .hw_fs(hw_fs), .fs_out(fs_out), .to_flag(to_flag),
    .rst_n_out(rst_n_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic strobe_fs(input logic [FS_W-1:0] v);
    @(negedge clk) begin sw_fs = v; sw_fs_wr = 1'b1; end
    @(negedge clk) sw_fs_wr = 1'b0;
  endtask

  task automatic set_to(input logic [TO_W-1:0] v);
    @(negedge clk) to_code = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 fs", int'(fs_out), int'(HW));
    check("R1 flag", int'(to_flag), 0);
    check("R1 rst_n", int'(rst_n_out), 1);
  endtask

  task automatic t_unarmed;
    set_to(0);
    strobe_fs(4'd3);
    check("R2 fs load", int'(fs_out), 3);
    ticks(40);
    check("R3 no pulse", int'(rst_n_out), 1);
  endtask

  task automatic t_revert_prev;
    revert_sel = 1'b1;
    set_to(2);
    strobe_fs(4'd9);
    check("R2 fs load", int'(fs_out), 9);
    ticks(2 * TPS - 1);
    check("R4 before expiry", int'(rst_n_out), 1);
    check("R6 flag before", int'(to_flag), 0);
    ticks(1);
    check("R4 expiry", int'(rst_n_out), 0);
    check("R6 flag set", int'(to_flag), 1);
    check("R8 prior code", int'(fs_out), 3);
    ticks(PULSE - 1);
    check("R5 still low", int'(rst_n_out), 0);
    ticks(1);
    check("R5 released", int'(rst_n_out), 1);
    check("R6 flag held", int'(to_flag), 1);
    set_to(0);
    check("R6 flag cleared", int'(to_flag), 0);
  endtask

  task automatic t_revert_hw;
    revert_sel = 1'b0;
    set_to(1);
    strobe_fs(4'd12);
    ticks(TPS);
    check("R7 low", int'(rst_n_out), 0);
    check("R7 strap code", int'(fs_out), int'(HW));
    ticks(PULSE);
    set_to(0);
  endtask

  task automatic t_clear;
    set_to(1);
    strobe_fs(4'd4);
    ticks(TPS / 2);
    set_to(0);
    ticks(3 * TPS);
    check("R9 no pulse", int'(rst_n_out), 1);
    check("R9 code kept", int'(fs_out), 4);
    check("R9 no flag", int'(to_flag), 0);
  endtask

  task automatic t_div;
    revert_sel = 1'b0;
    set_to(1);
    @(negedge clk) div_wr = 1'b1;
    @(negedge clk) div_wr = 1'b0;
    check("R10 code unchanged", int'(fs_out), 4);
    ticks(SETTLE + TPS - 1);
    check("R10 before expiry", int'(rst_n_out), 1);
    ticks(1);
    check("R10 expiry", int'(rst_n_out), 0);
    check("R10 strap code", int'(fs_out), int'(HW));
    ticks(PULSE);
    set_to(0);
  endtask

  task automatic t_restart;
    set_to(1);
    strobe_fs(4'd5);
    ticks(7);
    set_to(2);
    ticks(2 * TPS - 1);
    check("R11 no early expiry", int'(rst_n_out), 1);
    ticks(1);
    check("R11 expiry after restart", int'(rst_n_out), 0);
    ticks(PULSE);
    set_to(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_revert_prev();
    t_revert_hw();
    t_clear();
    t_div();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule